// File: doc/BRIEF.md
# Multi-Mode Configurable Flip-Flop Cell

This block is the sequential stage at the end of one channel of a programmable logic fabric. A configuration word picks one of seven functions at run time: a plain D flip-flop, a pass-through of the channel's filtered term, a flip-flop that captures on both edges of its clock source, a toggle flip-flop, a JK flip-flop, a level-sensitive latch, or a bit-serial adder/subtractor. Up to three term signals arrive from the channel's logic array and act as data, J/K, T, enable or operands, depending on the selected function. One registered bit leaves the cell.

All state is held in the main clock domain, and the reset is synchronous. The edge-driven functions advance on *events*. When the main clock is the source, every cycle is a rising event. When the alternate clock is the source, that clock is synchronized and its edges are detected, which gives rising and falling events. An oscillation guard watches the unclamped function result. If that result has changed on too many consecutive cycles, as happens when a combinational feedback loop through the fabric oscillates, the guard pins the output to a configured value until the result settles.

Top module: `cfg_seq_cell`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, all internal state clears, and `cell_out` reads 0 after that edge.
- R2: Function code 0 (config bits [2:0] = 0) is a D flip-flop. On each rising event, `cell_out` takes the value of `term_a`, visible after that edge. With the main clock as source, this is a one-cycle delay of `term_a`.
- R3: Function code 1 is a pass-through. `cell_out` equals `term_a` delayed by one `clk` cycle whatever the clock source bit says, even when the alternate clock never moves.
- R4: Function code 2 is a dual-edge flip-flop. `term_a` is captured on both rising and falling events of the selected source. With the main clock as source, it behaves as in R2.
- R5: Function code 3 is a toggle flip-flop. On a rising event, `cell_out` inverts when `term_a` is 1 and holds when `term_a` is 0.
- R6: Function code 4 is a JK flip-flop, with J = `term_a` and K = `term_b`. On a rising event, JK = 00 holds, 01 clears, 10 sets and 11 inverts.
- R7: Function code 5 is a latch. While `term_en` is 1, `cell_out` follows `term_a` one cycle later. While `term_en` is 0, it holds.
- R8: Function code 6 is a serial arithmetic unit. On each rising event, `cell_out` becomes `term_a` XOR `term_b` XOR the stored carry. With config bit 4 = 0 it adds: the carry becomes the majority of the three. With bit 4 = 1 it subtracts `term_b` from `term_a`: the borrow becomes (!a & b) | (!(a^b) & borrow). The carry is cleared in every cycle the function code is not 6.
- R9: Config bit 3 = 1 selects the alternate clock. `alt_clk` passes through a two-stage synchronizer. A change on `alt_clk` applied before edge k takes effect at `cell_out` after edge k+2, and not earlier. Without a change there are no events, so R2, R4, R5, R6 and R8 hold their output.
- R10: Function code 7 drives `cell_out` to 0 after the next edge, whatever the terms are.
- R11: With config bit 16 = 0, the unclamped result may change on 4 consecutive cycles (parameter `LOOP_WIN`). From the edge of the fourth change onward, `cell_out` is forced to config bit 17. The force lasts while the changes continue, and the unclamped value returns on the first cycle without a change. With bit 16 = 1 the clamp never acts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main channel clock; every register runs on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| alt_clk | input | 1 | Alternate clock source, sampled and edge-detected in the `clk` domain |
| term_a | input | 1 | Data, J, T or first operand |
| term_b | input | 1 | K or second operand |
| term_en | input | 1 | Latch enable |
| cfg_word | input | 32 | Function code [2:0], clock source [3], subtract [4], clamp disable [16], clamp value [17] |
| cell_out | output | 1 | Registered cell output |

## Verification
A wrong internal value shows at `cell_out` either one edge after its next use or after the synchronizer delay. A stale carry corrupts the very next arithmetic bit. A dual-edge capture register that holds the wrong value appears on the cycle after the opposite event. A synchronizer that is one stage short moves the output change a full cycle early, which the checks taken two cycles after an alternate-clock change catch. A run counter that counts wrongly shows as a clamp that engages one cycle early or late in a toggle run, or that fails to release once the terms stop changing.

// File: rtl/cfg_cell_pkg.sv
package cfg_cell_pkg;

  localparam int CFG_W       = 32;
  localparam int FN_LSB      = 0;
  localparam int FN_W        = 3;
  localparam int SRC_BIT     = 3;
  localparam int SUB_BIT     = 4;
  localparam int CLAMP_OFF_B = 16;
  localparam int CLAMP_VAL_B = 17;

  typedef enum logic [FN_W-1:0] {
    FN_DFF   = 3'd0,
    FN_PASS  = 3'd1,
    FN_DUAL  = 3'd2,
    FN_TOG   = 3'd3,
    FN_JK    = 3'd4,
    FN_LATCH = 3'd5,
    FN_ARITH = 3'd6,
    FN_RSVD  = 3'd7
  } fn_e;

  typedef struct packed {
    fn_e  fn;
    logic use_alt;
    logic subtract;
    logic clamp_off;
    logic clamp_val;
  } cell_cfg_t;

  function automatic cell_cfg_t decode_cfg(input logic [CFG_W-1:0] w);
    cell_cfg_t c;
    c.fn        = fn_e'(w[FN_LSB +: FN_W]);
    c.use_alt   = w[SRC_BIT];
    c.subtract  = w[SUB_BIT];
    c.clamp_off = w[CLAMP_OFF_B];
    c.clamp_val = w[CLAMP_VAL_B];
    return c;
  endfunction

endpackage

// File: rtl/clk_event_gen.sv
module clk_event_gen #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic alt_clk,
  input  logic use_alt,
  output logic ev_rise,
  output logic ev_fall
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= alt_clk;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], alt_clk};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q[LAST];
  end

  always_comb begin
    if (use_alt) begin
      ev_rise = sync_q[LAST] & ~prev_q;
      ev_fall = ~sync_q[LAST] & prev_q;
    end else begin
      ev_rise = 1'b1;
      ev_fall = 1'b0;
    end
  end

endmodule

// File: rtl/dual_edge_capture.sv
module dual_edge_capture (
  input  logic clk,
  input  logic rst,
  input  logic ev_rise,
  input  logic ev_fall,
  input  logic d,
  output logic q_nxt
);
  logic rise_q, fall_q, last_fall_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_q      <= 1'b0;
      fall_q      <= 1'b0;
      last_fall_q <= 1'b0;
    end else begin
      if (ev_rise) begin
        rise_q      <= d;
        last_fall_q <= 1'b0;
      end else if (ev_fall) begin
        fall_q      <= d;
        last_fall_q <= 1'b1;
      end
    end
  end

  always_comb begin
    if (ev_rise || ev_fall) q_nxt = d;
    else if (last_fall_q)   q_nxt = fall_q;
    else                    q_nxt = rise_q;
  end

  assert_rise_capture_R4: assert property (@(posedge clk) disable iff (rst)
    ev_rise |=> (rise_q == $past(d)));

  assert_fall_capture_R4: assert property (@(posedge clk) disable iff (rst)
    (ev_fall && !ev_rise) |=> (fall_q == $past(d)));

endmodule

// File: rtl/serial_addsub.sv
module serial_addsub (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic ev,
  input  logic subtract,
  input  logic a,
  input  logic b,
  output logic sum
);
  logic carry_q, carry_nxt;

  always_comb begin
    sum = a ^ b ^ carry_q;
    if (subtract) carry_nxt = (~a & b) | (~(a ^ b) & carry_q);
    else          carry_nxt = (a & b) | (carry_q & (a ^ b));
  end

  always_ff @(posedge clk) begin
    if (rst || !active) carry_q <= 1'b0;
    else if (ev)        carry_q <= carry_nxt;
  end

  assert_carry_clear_R8: assert property (@(posedge clk) disable iff (rst)
    !active |=> !carry_q);

endmodule

// File: rtl/osc_clamp.sv
module osc_clamp #(
  parameter int LOOP_WIN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic changed,
  input  logic enable,
  output logic engage
);
  localparam int RUN_W = $clog2(LOOP_WIN + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(LOOP_WIN);

  logic [RUN_W-1:0] run_q, run_nxt;

  always_comb begin
    if (!changed)              run_nxt = '0;
    else if (run_q == RUN_MAX) run_nxt = RUN_MAX;
    else                       run_nxt = run_q + 1'b1;
    engage = enable && (run_nxt == RUN_MAX);
  end

  always_ff @(posedge clk) begin
    if (rst) run_q <= '0;
    else     run_q <= run_nxt;
  end

  assert_run_bounded_R11: assert property (@(posedge clk) disable iff (rst)
    run_q <= RUN_MAX);

  assert_run_restart_R11: assert property (@(posedge clk) disable iff (rst)
    !changed |=> (run_q == '0));

endmodule

// File: rtl/cfg_seq_cell.sv
module cfg_seq_cell
  import cfg_cell_pkg::*;
#(
  parameter int LOOP_WIN    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alt_clk,
  input  logic             term_a,
  input  logic             term_b,
  input  logic             term_en,
  input  logic [CFG_W-1:0] cfg_word,
  output logic             cell_out
);
  cell_cfg_t cfg;
  logic      ev_rise, ev_fall;
  logic      dual_nxt, arith_sum;
  logic      state_q, state_nxt;
  logic      engage, clamp_q, bad_code;
  logic      unused_cfg;

  assign cfg        = decode_cfg(cfg_word);
  assign bad_code   = (cfg.fn == FN_RSVD);
  assign unused_cfg = ^{cfg_word[CFG_W-1:CLAMP_VAL_B+1], cfg_word[CLAMP_OFF_B-1:SUB_BIT+1]};

  clk_event_gen #(.SYNC_STAGES(SYNC_STAGES)) u_events (
    .clk     (clk),
    .rst     (rst),
    .alt_clk (alt_clk),
    .use_alt (cfg.use_alt),
    .ev_rise (ev_rise),
    .ev_fall (ev_fall)
  );

  dual_edge_capture u_dual (
    .clk     (clk),
    .rst     (rst),
    .ev_rise (ev_rise),
    .ev_fall (ev_fall),
    .d       (term_a),
    .q_nxt   (dual_nxt)
  );

  serial_addsub u_arith (
    .clk      (clk),
    .rst      (rst),
    .active   (cfg.fn == FN_ARITH),
    .ev       (ev_rise),
    .subtract (cfg.subtract),
    .a        (term_a),
    .b        (term_b),
    .sum      (arith_sum)
  );

  always_comb begin
    state_nxt = state_q;
    unique case (cfg.fn)
      FN_DFF:   if (ev_rise) state_nxt = term_a;
      FN_PASS:  state_nxt = term_a;
      FN_DUAL:  state_nxt = dual_nxt;
      FN_TOG:   if (ev_rise) state_nxt = state_q ^ term_a;
      FN_JK: begin
        if (ev_rise) begin
          unique case ({term_a, term_b})
            2'b00: state_nxt = state_q;
            2'b01: state_nxt = 1'b0;
            2'b10: state_nxt = 1'b1;
            2'b11: state_nxt = ~state_q;
          endcase
        end
      end
      FN_LATCH: if (term_en) state_nxt = term_a;
      FN_ARITH: if (ev_rise) state_nxt = arith_sum;
      FN_RSVD:  state_nxt = 1'b0;
    endcase
  end

  osc_clamp #(.LOOP_WIN(LOOP_WIN)) u_clamp (
    .clk     (clk),
    .rst     (rst),
    .changed (state_nxt != state_q),
    .enable  (!cfg.clamp_off),
    .engage  (engage)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= 1'b0;
      clamp_q  <= 1'b0;
      cell_out <= 1'b0;
    end else begin
      state_q <= state_nxt;
      clamp_q <= engage;
      if (bad_code)    cell_out <= 1'b0;
      else if (engage) cell_out <= cfg.clamp_val;
      else             cell_out <= state_nxt;
    end
  end

  assert_bad_code_zero_R10: assert property (@(posedge clk) disable iff (rst)
    bad_code |=> !cell_out);

  assert_clamp_force_R11: assert property (@(posedge clk) disable iff (rst)
    (engage && !bad_code) |=> (cell_out == $past(cfg.clamp_val)));

  assert_hold_no_event_R9: assert property (@(posedge clk) disable iff (rst)
    (cfg.fn == FN_DFF && !ev_rise && !clamp_q) |=> $stable(cell_out));

endmodule

// File: tb/test_cfg_seq_cell.sv
`timescale 1ns/1ps
module test_cfg_seq_cell;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        alt_clk = 1'b0;
  logic        term_a = 1'b0, term_b = 1'b0, term_en = 1'b0;
  logic [31:0] cfg_word = '0;
  logic        cell_out;
  int          n_checks = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  cfg_seq_cell i_cfg_seq_cell (
    .clk(clk), .rst(rst), .alt_clk(alt_clk), .term_a(term_a),
    .term_b(term_b), .term_en(term_en), .cfg_word(cfg_word), .cell_out(cell_out)
  );

  function automatic logic [31:0] mk(input int fn, input bit alt, input bit sub,
                                     input bit clamp_off, input bit cval);
    logic [31:0] w = '0;
    w[2:0] = fn[2:0];
    w[3]   = alt;
    w[4]   = sub;
    w[16]  = clamp_off;
    w[17]  = cval;
    return w;
  endfunction

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic check(input string req, input logic got, input logic exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: cell_out=%b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; alt_clk = 1'b0; term_a = 0; term_b = 0; term_en = 0;
    step(2);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    cfg_word = mk(3, 0, 0, 1, 0);
    term_a = 1'b1;
    rst = 1'b1;
    step(2);
    check("R1 reset", cell_out, 1'b0);
    rst = 1'b0;
  endtask

  task automatic t_dff();
    logic [7:0] pat = 8'b1011_0010;
    do_reset();
    cfg_word = mk(0, 0, 0, 1, 0);
    for (int i = 0; i < 8; i++) begin
      term_a = pat[i];
      term_b = ~pat[i];
      step();
      check("R2 dff", cell_out, pat[i]);
    end
  endtask

  task automatic t_pass();
    logic [5:0] pat = 6'b011010;
    do_reset();
    cfg_word = mk(1, 1, 0, 1, 0);
    for (int i = 0; i < 6; i++) begin
      term_a = pat[i];
      step();
      check("R3 pass with idle alt clock", cell_out, pat[i]);
    end
  endtask

  task automatic t_dual();
    do_reset();
    cfg_word = mk(2, 0, 0, 1, 0);
    term_a = 1; step(); check("R4 dual main source", cell_out, 1'b1);
    term_a = 0; step(); check("R4 dual main source", cell_out, 1'b0);
    cfg_word = mk(2, 1, 0, 1, 0);
    term_a = 1; alt_clk = 1; step(3);
    check("R4 dual rising capture", cell_out, 1'b1);
    term_a = 0; step(3);
    check("R4 dual holds between events", cell_out, 1'b1);
    alt_clk = 0; step(3);
    check("R4 dual falling capture", cell_out, 1'b0);
    term_a = 1; step(3);
    check("R4 dual holds after fall", cell_out, 1'b0);
    alt_clk = 1; step(3);
    check("R4 dual second rise", cell_out, 1'b1);
  endtask

  task automatic t_altsrc();
    do_reset();
    cfg_word = mk(0, 1, 0, 1, 0);
    for (int i = 0; i < 5; i++) begin
      term_a = i[0];
      step();
      check("R9 no alt edge holds", cell_out, 1'b0);
    end
    term_a = 1; alt_clk = 1; step(2);
    check("R9 not before sync delay", cell_out, 1'b0);
    step();
    check("R9 update after sync delay", cell_out, 1'b1);
  endtask

  task automatic t_toggle();
    logic exp = 0;
    do_reset();
    cfg_word = mk(3, 0, 0, 1, 0);
    term_a = 1;
    for (int i = 0; i < 3; i++) begin
      step(); exp = ~exp; check("R5 toggle T=1", cell_out, exp);
    end
    term_a = 0;
    for (int i = 0; i < 2; i++) begin
      step(); check("R5 toggle T=0 holds", cell_out, exp);
    end
  endtask

  task automatic t_jk();
    do_reset();
    cfg_word = mk(4, 0, 0, 1, 0);
    term_a = 1; term_b = 0; step(); check("R6 jk set", cell_out, 1'b1);
    term_a = 0; term_b = 0; step(); check("R6 jk hold", cell_out, 1'b1);
    term_a = 0; term_b = 1; step(); check("R6 jk clear", cell_out, 1'b0);
    term_a = 1; term_b = 1; step(); check("R6 jk invert", cell_out, 1'b1);
    step(); check("R6 jk invert", cell_out, 1'b0);
  endtask

  task automatic t_latch();
    do_reset();
    cfg_word = mk(5, 0, 0, 1, 0);
    term_en = 1; term_a = 1; step(); check("R7 latch open", cell_out, 1'b1);
    term_en = 0; term_a = 0; step(2); check("R7 latch closed holds", cell_out, 1'b1);
    term_en = 1; step(); check("R7 latch reopens", cell_out, 1'b0);
  endtask

  task automatic t_arith(input bit sub, input logic [7:0] x, input logic [7:0] y);
    logic c = 0;
    logic s;
    do_reset();
    cfg_word = mk(6, 0, sub, 1, 0);
    for (int i = 0; i < 8; i++) begin
      term_a = x[i]; term_b = y[i];
      s = x[i] ^ y[i] ^ c;
      if (sub) c = (~x[i] & y[i]) | (~(x[i] ^ y[i]) & c);
      else     c = (x[i] & y[i]) | (c & (x[i] ^ y[i]));
      step();
      check(sub ? "R8 subtract bit" : "R8 add bit", cell_out, s);
    end
  endtask

  task automatic t_carry_clear();
    do_reset();
    cfg_word = mk(6, 0, 0, 1, 0);
    term_a = 1; term_b = 1; step();
    check("R8 carry generate", cell_out, 1'b0);
    cfg_word = mk(0, 0, 0, 1, 0);
    term_a = 0; term_b = 0; step();
    cfg_word = mk(6, 0, 0, 1, 0);
    step();
    check("R8 carry cleared on mode exit", cell_out, 1'b0);
  endtask

  task automatic t_bad_code();
    do_reset();
    cfg_word = mk(0, 0, 0, 1, 0);
    term_a = 1; step(); check("R10 before", cell_out, 1'b1);
    cfg_word = mk(7, 0, 0, 1, 1);
    step(); check("R10 reserved code drives 0", cell_out, 1'b0);
    step(); check("R10 reserved code drives 0", cell_out, 1'b0);
  endtask

  task automatic t_clamp();
    logic exp = 0;
    do_reset();
    cfg_word = mk(3, 0, 0, 0, 1);
    term_a = 1;
    for (int i = 1; i <= 8; i++) begin
      step();
      exp = ~exp;
      check("R11 clamp run", cell_out, (i >= 4) ? 1'b1 : exp);
    end
    term_a = 0; step();
    check("R11 clamp releases", cell_out, 1'b0);
    do_reset();
    cfg_word = mk(3, 0, 0, 1, 1);
    term_a = 1; exp = 0;
    for (int i = 1; i <= 6; i++) begin
      step(); exp = ~exp;
      check("R11 clamp disabled", cell_out, exp);
    end
  endtask

  initial begin
    t_reset();
    t_dff();
    t_pass();
    t_dual();
    t_altsrc();
    t_toggle();
    t_jk();
    t_latch();
    t_arith(1'b0, 8'h5B, 8'h37);
    t_arith(1'b1, 8'h23, 8'h6C);
    t_carry_clear();
    t_bad_code();
    t_clamp();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule